// File: doc/BRIEF.md
# Command Queue SPI Sequencer

This block runs a stream of 32-bit command words for a controller that drives two SPI buses side by side. Each word supplies an 8-bit immediate value and a set of flags that decide how long the transfer is, whether outgoing bytes come from the TX data queue, whether incoming bytes go to the RX data queue, whether the two buses carry the same byte or two different bytes, and which buses deliver received bytes. The block pops words from a command queue, keeps the word in a snapshot register, and then exchanges one byte per bus for each transfer step until the remaining count reaches zero.

All queues sit outside the block and are show-ahead: the block reads the head entries and their fill levels and returns pop or push counts within the same cycle. The byte exchange with the two buses also completes within one cycle. When a transfer ends, the block discards TX bytes and inserts zero RX bytes until the running byte count of each queue is a multiple of the word size again. This keeps the data queues aligned to 32-bit words for the software that fills and drains them.

Top module: `cmdq_spi_seq`

## Requirements
- R1: The command word fields are: immediate value in bits 7:0, data-mode flag in bit 8, power-of-two flag in bit 9, bus select in bits 11:10 (bit 10 is bus 0, bit 11 is bus 1), transmit in bit 12, receive in bit 13, stripe in bit 14. A popped word is copied to `snapshot_o` on the next clock edge. An all-zero word is consumed and causes no bus exchange.
- R2: When the data-mode flag is clear, the word is a single-step transfer with the immediate byte placed on both buses, provided transmit or receive is set. It pops no TX byte. When transmit and receive are both clear, there is no exchange at all.
- R3: When the data-mode flag is set and the power-of-two flag is clear, the step count is set by the immediate value.
- R4: When the data-mode and power-of-two flags are both set, the length is 2 raised to the immediate value, for immediate values up to 31.
- R5: A data-mode word with a length of zero is consumed without any exchange.
- R6: `tx_pop_cnt_o` gives the number of TX bytes taken in a cycle (0, 1 or 2). A step that must send TX bytes waits until the TX level covers every byte it needs, and meanwhile makes no exchange.
- R7: A receiving step waits while `rx_free_i` is below the number of bytes it would push, and meanwhile makes no exchange.
- R8: `bus_tx_o` carries bus 0 in bits 7:0 and bus 1 in bits 15:8. When stripe is set together with transmit or receive, the TX head byte goes to bus 0 and the next byte to bus 1, and both are popped. Otherwise one byte is sent on both buses.
- R9: When the remaining count is above 1, both buses are selected and striping is active, a step lowers the count by 2. In every other case a step lowers it by 1.
- R10: When receive is set, a step pushes one byte for each selected bus. `rx_data_o` bits 7:0 hold the first pushed byte and bits 15:8 the second. Bus 0 is pushed before bus 1.
- R11: When the count reaches 0, TX bytes are popped and dropped, and zero bytes are pushed to RX, until the total number of popped TX bytes and the total number of pushed RX bytes are each a multiple of 4.
- R12: `busy_o` is high while a command is pending or a transfer or its alignment is in progress, and low once everything has drained.
- R13: A data-mode word with transmit clear sends zero bytes on both buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command queue not empty |
| cmd_data_i | input | 32 | Command queue head word |
| cmd_pop_o | output | 1 | Pops the command head |
| tx_level_i | input | LVL_W | Bytes held in the TX queue |
| tx_data_i | input | 16 | TX head byte in bits 7:0, next byte in bits 15:8 |
| tx_pop_cnt_o | output | 2 | TX bytes popped this cycle |
| rx_free_i | input | LVL_W | Free byte slots in the RX queue |
| rx_push_cnt_o | output | 2 | RX bytes pushed this cycle |
| rx_data_o | output | 16 | Pushed RX bytes, first in bits 7:0 |
| bus_xfer_o | output | 1 | Byte exchange strobe for both buses |
| bus_tx_o | output | 16 | Bytes sent, bus 0 in bits 7:0 |
| bus_rx_i | input | 16 | Bytes received in the same cycle, bus 0 in bits 7:0 |
| snapshot_o | output | 32 | Copy of the current command word |
| busy_o | output | 1 | Work pending or in progress |

## Verification
The bench uses the default parameters: a 6-bit queue level, 4-byte alignment and an exponent limit of 31. With these, queue levels up to 63 can be modelled, so the bench can force both stall conditions, starving the TX queue and limiting RX space to a single slot, and then release them. The power-of-two path is exercised with a small exponent so that the whole transfer runs within the bench. Bus responses are derived from the transmitted bytes by a fixed, different function on each lane, which shows whether a received byte came from the correct bus and was pushed in the correct order.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int BYTE_W = 8;
  localparam int NBUS   = 2;

  typedef struct packed {
    logic [16:0] rsvd;
    logic        stripe;
    logic        rx;
    logic        tx;
    logic [1:0]  bus_sel;
    logic        pow2;
    logic        dmode;
    logic [7:0]  imm;
  } cmd_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_XFER  = 2'd1,
    S_ALIGN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cmdq_len_dec.sv
module cmdq_len_dec
  import cmdq_pkg::*;
#(
  parameter int MAX_EXP = 31,
  parameter int LEN_W   = 32
) (
  input  cmd_t             cmd_i,
  output logic [LEN_W-1:0] len_o
);
  logic [7:0] exp_c;

  always_comb begin
    exp_c = (cmd_i.imm > 8'(MAX_EXP)) ? 8'(MAX_EXP) : cmd_i.imm;
    if (!cmd_i.dmode)
      len_o = (cmd_i.tx || cmd_i.rx) ? LEN_W'(1) : '0;
    else if (cmd_i.pow2)
      len_o = LEN_W'(1) << exp_c;
    else
      len_o = LEN_W'(cmd_i.imm);
  end
endmodule

// File: rtl/cmdq_lane_mux.sv
module cmdq_lane_mux
  import cmdq_pkg::*;
(
  input  cmd_t                   snap_i,
  input  logic [NBUS*BYTE_W-1:0] tx_data_i,
  input  logic [NBUS*BYTE_W-1:0] bus_rx_i,
  output logic [NBUS*BYTE_W-1:0] bus_tx_o,
  output logic [1:0]             tx_need_o,
  output logic [1:0]             rx_need_o,
  output logic [NBUS*BYTE_W-1:0] rx_word_o,
  output logic                   striped_o
);
  logic [BYTE_W-1:0] lane_b [NBUS];

  assign striped_o = snap_i.stripe && (snap_i.tx || snap_i.rx);

  for (genvar g = 0; g < NBUS; g++) begin : g_lane
    always_comb begin
      if (!snap_i.dmode)
        lane_b[g] = snap_i.imm;
      else if (snap_i.tx)
        lane_b[g] = striped_o ? tx_data_i[g*BYTE_W +: BYTE_W] : tx_data_i[BYTE_W-1:0];
      else
        lane_b[g] = '0;
    end
    assign bus_tx_o[g*BYTE_W +: BYTE_W] = lane_b[g];
  end

  always_comb begin
    tx_need_o = '0;
    if (snap_i.dmode && snap_i.tx) tx_need_o = striped_o ? 2'd2 : 2'd1;
    rx_need_o = snap_i.rx ? 2'($countones(snap_i.bus_sel)) : 2'd0;
    // a lone bus 1 byte moves into the first slot
    if (snap_i.bus_sel == 2'b10)
      rx_word_o = {{BYTE_W{1'b0}}, bus_rx_i[2*BYTE_W-1:BYTE_W]};
    else
      rx_word_o = bus_rx_i;
  end
endmodule

// File: rtl/cmdq_align_ctr.sv
module cmdq_align_ctr #(
  parameter int ALIGN_BYTES = 4,
  localparam int CW = (ALIGN_BYTES > 2) ? $clog2(ALIGN_BYTES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] add_i,
  output logic       aligned_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(add_i);
  end

  assign aligned_o = (cnt_q == '0);
endmodule

// File: rtl/cmdq_spi_seq.sv
module cmdq_spi_seq
  import cmdq_pkg::*;
#(
  parameter int LVL_W       = 6,
  parameter int ALIGN_BYTES = 4,
  parameter int MAX_EXP     = 31
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [31:0]            cmd_data_i,
  output logic                   cmd_pop_o,
  input  logic [LVL_W-1:0]       tx_level_i,
  input  logic [NBUS*BYTE_W-1:0] tx_data_i,
  output logic [1:0]             tx_pop_cnt_o,
  input  logic [LVL_W-1:0]       rx_free_i,
  output logic [1:0]             rx_push_cnt_o,
  output logic [NBUS*BYTE_W-1:0] rx_data_o,
  output logic                   bus_xfer_o,
  output logic [NBUS*BYTE_W-1:0] bus_tx_o,
  input  logic [NBUS*BYTE_W-1:0] bus_rx_i,
  output logic [31:0]            snapshot_o,
  output logic                   busy_o
);
  localparam int LEN_W = MAX_EXP + 1;

  seq_state_e       state_q;
  cmd_t             snap_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] len_c;
  logic [LEN_W-1:0] dec_c;
  logic [1:0]       tx_need, rx_need;
  logic [NBUS*BYTE_W-1:0] rx_word;
  logic             striped, step, tx_ok, rx_ok;
  logic             tx_aligned, rx_aligned, tx_disc, rx_pad;

  cmdq_len_dec #(.MAX_EXP(MAX_EXP), .LEN_W(LEN_W)) i_len_dec (
    .cmd_i (cmd_t'(cmd_data_i)),
    .len_o (len_c)
  );

  cmdq_lane_mux i_lane_mux (
    .snap_i    (snap_q),
    .tx_data_i (tx_data_i),
    .bus_rx_i  (bus_rx_i),
    .bus_tx_o  (bus_tx_o),
    .tx_need_o (tx_need),
    .rx_need_o (rx_need),
    .rx_word_o (rx_word),
    .striped_o (striped)
  );

  cmdq_align_ctr #(.ALIGN_BYTES(ALIGN_BYTES)) i_tx_align (
    .clk_i (clk_i), .rst_ni (rst_ni), .add_i (tx_pop_cnt_o), .aligned_o (tx_aligned)
  );

  cmdq_align_ctr #(.ALIGN_BYTES(ALIGN_BYTES)) i_rx_align (
    .clk_i (clk_i), .rst_ni (rst_ni), .add_i (rx_push_cnt_o), .aligned_o (rx_aligned)
  );

  assign tx_ok   = tx_level_i >= LVL_W'(tx_need);
  assign rx_ok   = rx_free_i >= LVL_W'(rx_need);
  assign step    = (state_q == S_XFER) && tx_ok && rx_ok;
  assign tx_disc = (state_q == S_ALIGN) && !tx_aligned && (tx_level_i != '0);
  assign rx_pad  = (state_q == S_ALIGN) && !rx_aligned && (rx_free_i != '0);
  assign dec_c   = (rem_q > LEN_W'(1) && snap_q.bus_sel == 2'b11 && striped) ? LEN_W'(2) : LEN_W'(1);

  assign cmd_pop_o     = (state_q == S_IDLE) && cmd_valid_i;
  assign bus_xfer_o    = step;
  assign tx_pop_cnt_o  = step ? tx_need : {1'b0, tx_disc};
  assign rx_push_cnt_o = step ? rx_need : {1'b0, rx_pad};
  assign rx_data_o     = step ? rx_word : '0;
  assign snapshot_o    = snap_q;
  assign busy_o        = (state_q != S_IDLE) || cmd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      snap_q  <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_pop_o) begin
          snap_q <= cmd_t'(cmd_data_i);
          if (len_c != '0) begin
            rem_q   <= len_c;
            state_q <= S_XFER;
          end
        end
        S_XFER: if (step) begin
          rem_q <= rem_q - dec_c;
          if (rem_q == dec_c) state_q <= S_ALIGN;
        end
        S_ALIGN: if (tx_aligned && rx_aligned) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6
  a_r6_tx_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LVL_W'(tx_pop_cnt_o) <= tx_level_i);
  // R7
  a_r7_rx_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LVL_W'(rx_push_cnt_o) <= rx_free_i);
  // R10
  a_r10_push_per_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_xfer_o |-> (rx_push_cnt_o == (snap_q.rx ? 2'($countones(snap_q.bus_sel)) : 2'd0)));
  // R11
  a_r11_aligned_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && $past(state_q) == S_ALIGN) |-> (tx_aligned && rx_aligned));
  // R12
  a_r12_busy_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i || bus_xfer_o) |-> busy_o);
  // R1
  a_r1_no_xfer_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pop_o |-> !bus_xfer_o && rx_push_cnt_o == 2'd0);
endmodule

// File: tb/test_cmdq_spi_seq.sv
module test_cmdq_spi_seq;
  localparam int CLK_P = 10;
  localparam int LVL_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_pop;
  logic [LVL_W-1:0] tx_level = '0;
  logic [15:0] tx_data = '0;
  logic [1:0]  tx_pop_cnt;
  logic [LVL_W-1:0] rx_free = '0;
  logic [1:0]  rx_push_cnt;
  logic [15:0] rx_data;
  logic        bus_xfer;
  logic [15:0] bus_tx, bus_rx;
  logic [31:0] snapshot;
  logic        busy;

  int total = 0;
  int bad = 0;
  int bus_cnt = 0;
  int rx_room = 60;
  string cur_req = "R0";

  logic [31:0] cmd_q[$];
  logic [7:0]  tx_q[$];
  logic [15:0] exp_bus[$];
  logic [7:0]  exp_rx[$];

  always #(CLK_P/2) clk = ~clk;

  assign bus_rx = {bus_tx[15:8] ^ 8'h5A, ~bus_tx[7:0]};

  cmdq_spi_seq #(.LVL_W(LVL_W)) i_cmdq_spi_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_pop_o(cmd_pop),
    .tx_level_i(tx_level), .tx_data_i(tx_data), .tx_pop_cnt_o(tx_pop_cnt),
    .rx_free_i(rx_free), .rx_push_cnt_o(rx_push_cnt), .rx_data_o(rx_data),
    .bus_xfer_o(bus_xfer), .bus_tx_o(bus_tx), .bus_rx_i(bus_rx),
    .snapshot_o(snapshot), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dm, input bit p2, input bit tx, input bit rx,
                                     input bit st, input logic [1:0] sel, input logic [7:0] imm);
    return {17'b0, st, rx, tx, sel, p2, dm, imm};
  endfunction

  task automatic drive();
    cmd_valid = cmd_q.size() > 0;
    cmd_data  = cmd_q.size() > 0 ? cmd_q[0] : '0;
    tx_level  = LVL_W'(tx_q.size());
    tx_data   = {tx_q.size() > 1 ? tx_q[1] : 8'h00, tx_q.size() > 0 ? tx_q[0] : 8'h00};
    rx_free   = LVL_W'(rx_room);
  endtask

  // queue models and scoreboard monitor
  initial begin : model
    forever begin
      logic p_cmd;
      logic [1:0] p_tx, p_rx;
      @(negedge clk);
      p_cmd = cmd_pop; p_tx = tx_pop_cnt; p_rx = rx_push_cnt;
      if (rst_n) begin
        if (bus_xfer) begin
          bus_cnt++;
          if (exp_bus.size() == 0) chk({cur_req, " unexpected exchange"}, bus_tx, 32'hFFFF_FFFF);
          else chk(cur_req, bus_tx, exp_bus.pop_front());
        end
        for (int i = 0; i < int'(p_rx); i++) begin
          if (exp_rx.size() == 0) chk({cur_req, " unexpected rx"}, rx_data[i*8 +: 8], 32'hFFFF_FFFF);
          else chk(cur_req, rx_data[i*8 +: 8], exp_rx.pop_front());
        end
      end
      @(posedge clk); #1;
      if (p_cmd && cmd_q.size() > 0) void'(cmd_q.pop_front());
      for (int i = 0; i < int'(p_tx); i++) if (tx_q.size() > 0) void'(tx_q.pop_front());
      rx_room -= int'(p_rx);
      drive();
    end
  end

  task automatic wait_idle(input string req);
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (cmd_q.size() == 0 && !busy) quiet++;
      else quiet = 0;
    end
    chk({req, " missing exchanges"}, exp_bus.size(), 0);
    chk({req, " missing rx"}, exp_rx.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int b0;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R1 reset snapshot", snapshot, 0);
    chk("R1 reset pop", cmd_pop, 0);
    chk("R6 reset xfer", bus_xfer, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 immediate transmit
    cur_req = "R2";
    exp_bus.push_back(16'hA5A5);
    cmd_q.push_back(mk(0,0,1,0,0,2'b01,8'hA5));
    wait_idle("R2");

    // R2 immediate receive, R10 order, R11 pad
    cur_req = "R10";
    exp_bus.push_back(16'h3C3C);
    exp_rx.push_back(8'hC3); exp_rx.push_back(8'h66);
    exp_rx.push_back(8'h00); exp_rx.push_back(8'h00);
    cmd_q.push_back(mk(0,0,0,1,0,2'b11,8'h3C));
    wait_idle("R10");

    // R2 neither transmit nor receive
    cur_req = "R2";
    b0 = bus_cnt;
    cmd_q.push_back(mk(0,0,0,0,0,2'b01,8'h77));
    wait_idle("R2");
    chk("R2 no exchange", bus_cnt, b0);
    chk("R1 snapshot", snapshot, mk(0,0,0,0,0,2'b01,8'h77));

    // R1 all-zero word
    cur_req = "R1";
    cmd_q.push_back(32'h0);
    wait_idle("R1");
    chk("R1 no exchange", bus_cnt, b0);
    chk("R1 snapshot zero", snapshot, 0);

    // R3 direct length, R11 discard
    cur_req = "R3";
    for (int i = 0; i < 4; i++) tx_q.push_back(8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) exp_bus.push_back({2{8'h10 + 8'(i)}});
    cmd_q.push_back(mk(1,0,1,0,0,2'b01,8'd3));
    wait_idle("R3");
    chk("R11 tx discard", tx_q.size(), 0);

    // R8 stripe, R9 double step, R10 both buses
    cur_req = "R8";
    for (int i = 0; i < 4; i++) tx_q.push_back(8'h20 + 8'(i));
    exp_bus.push_back(16'h2120); exp_bus.push_back(16'h2322);
    exp_rx.push_back(8'hDF); exp_rx.push_back(8'h7B);
    exp_rx.push_back(8'hDD); exp_rx.push_back(8'h79);
    cmd_q.push_back(mk(1,0,1,1,1,2'b11,8'd4));
    wait_idle("R8");
    chk("R8 tx used", tx_q.size(), 0);

    // R9 odd length: 3 -> 1 -> 0
    cur_req = "R9";
    for (int i = 0; i < 4; i++) tx_q.push_back(8'h30 + 8'(i));
    exp_bus.push_back(16'h3130); exp_bus.push_back(16'h3332);
    cmd_q.push_back(mk(1,0,1,0,1,2'b11,8'd3));
    wait_idle("R9");
    chk("R9 tx used", tx_q.size(), 0);

    // R4 power-of-two length, R10 bus 1 only
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin
      tx_q.push_back(8'h40 + 8'(i));
      exp_bus.push_back({2{8'h40 + 8'(i)}});
      exp_rx.push_back((8'h40 + 8'(i)) ^ 8'h5A);
    end
    cmd_q.push_back(mk(1,1,1,1,0,2'b10,8'd3));
    wait_idle("R4");
    chk("R4 tx used", tx_q.size(), 0);

    // R13 data mode without transmit
    cur_req = "R13";
    exp_bus.push_back(16'h0000); exp_bus.push_back(16'h0000);
    exp_rx.push_back(8'hFF); exp_rx.push_back(8'hFF);
    exp_rx.push_back(8'h00); exp_rx.push_back(8'h00);
    cmd_q.push_back(mk(1,0,0,1,0,2'b01,8'd2));
    wait_idle("R13");

    // R5 zero-length data word
    cur_req = "R5";
    b0 = bus_cnt;
    cmd_q.push_back(mk(1,0,1,1,0,2'b11,8'd0));
    wait_idle("R5");
    chk("R5 no exchange", bus_cnt, b0);

    // R6 TX stall, R12 busy
    cur_req = "R6";
    b0 = bus_cnt;
    cmd_q.push_back(mk(1,0,1,0,0,2'b01,8'd2));
    repeat (10) @(negedge clk);
    chk("R6 stalled", bus_cnt, b0);
    chk("R12 busy in stall", busy, 1);
    exp_bus.push_back(16'h5050); exp_bus.push_back(16'h5151);
    for (int i = 0; i < 4; i++) tx_q.push_back(8'h50 + 8'(i));
    wait_idle("R6");
    chk("R11 tx discard", tx_q.size(), 0);
    chk("R12 idle", busy, 0);

    // R7 RX stall
    cur_req = "R7";
    b0 = bus_cnt;
    rx_room = 1;
    cmd_q.push_back(mk(0,0,0,1,0,2'b11,8'h0F));
    repeat (10) @(negedge clk);
    chk("R7 stalled", bus_cnt, b0);
    chk("R12 busy in stall", busy, 1);
    exp_bus.push_back(16'h0F0F);
    exp_rx.push_back(8'hF0); exp_rx.push_back(8'h55);
    exp_rx.push_back(8'h00); exp_rx.push_back(8'h00);
    rx_room = 60;
    wait_idle("R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule